// File: doc/BRIEF.md
# Next-PC and Link Selector

This unit picks the address of the next instruction for a 32-bit core and forms the register write that a call instruction needs. It takes the current PC, the fetched instruction word, the value of the first source register, the ALU zero flag and two decoded strobes (conditional branch, absolute jump) plus a polarity strobe that turns the branch into branch-if-not-equal. It decodes the call and the register-indirect jump from the instruction word itself.

The logic is purely combinational. The surrounding core feeds the chosen address back into its PC register and routes the link outputs into its register-file write port. Four sources of control flow meet in one selector with a fixed priority. A call both redirects the PC and asks for the return address to be written into the link register.

Top module: `npc_link_unit`

## Requirements
- R1: With no branch taken, no jump strobe and no call or register jump decoded, the next PC is the current PC plus 4.
- R2: With the branch strobe high, the polarity strobe low and the zero flag high, the next PC is PC+4 plus the sign-extended instruction bits [15:0] shifted left by 2.
- R3: A branch is not taken (next PC is PC+4) when the zero flag does not match the polarity. With the polarity strobe high, the branch is taken when the zero flag is low.
- R4: A negative branch offset (instruction bit 15 set) moves the next PC backwards, because the offset is sign-extended.
- R5: With the jump strobe high, the next PC is current PC bits [31:28] followed by instruction bits [25:0] and two zero bits.
- R6: An instruction with opcode field [31:26] equal to 3 is a call. It takes the same target as R5, raises the link write enable, sets the link index to 31 and sets the link data to PC+4.
- R7: An instruction with opcode 0 and function field [5:0] equal to 6'b001000 is a register jump. Its next PC equals the register operand unchanged.
- R8: The priority is: register jump first, then absolute jump or call, then taken branch, then sequential flow.
- R9: For any instruction that is not a call, the link write enable is low and both the link index and the link data are zero.
- R10: PC+4 wraps modulo 2^32, so PC 0xFFFFFFFC followed by sequential flow gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | First source register value, target of a register jump |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| branch_i | input | 1 | Decoded conditional branch strobe |
| branch_ne_i | input | 1 | Branch polarity: 0 branches on zero, 1 on non-zero |
| jump_i | input | 1 | Decoded absolute jump strobe |
| next_pc_o | output | 32 | Selected address of the next instruction |
| link_we_o | output | 1 | Register-file write enable for the return address |
| link_idx_o | output | 5 | Destination register index of the link write |
| link_data_o | output | 32 | Return address to be written |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 16-bit branch offset, a 26-bit jump index and register 31 as the link register. These values give a 4-bit region field. A PC near the top of the address space can then show the wrap of the sequential adder and the kept upper nibble on absolute targets, and an all-ones jump index can fill every target bit below the nibble. Combined strobe patterns reach each level of the priority chain.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    FLOW_SEQ = 2'd0,
    FLOW_BR  = 2'd1,
    FLOW_JMP = 2'd2,
    FLOW_REG = 2'd3
  } flow_e;

  localparam int unsigned OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OPC_CALL  = 6'd3;
  localparam logic [OPC_W-1:0] FN_REGJMP = 6'b001000;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [OPC_W-1:0] funct,
  input  logic             alu_zero,
  input  logic             branch,
  input  logic             branch_ne,
  input  logic             jump,
  output flow_e            flow,
  output logic             is_call
);

  logic reg_jump;
  logic br_taken;

  always_comb begin
    reg_jump = (opcode == OPC_RTYPE) && (funct == FN_REGJMP);
    is_call  = (opcode == OPC_CALL);
    br_taken = branch && (alu_zero ^ branch_ne);
    if (reg_jump)              flow = FLOW_REG;
    else if (jump || is_call)  flow = FLOW_JMP;
    else if (br_taken)         flow = FLOW_BR;
    else                       flow = FLOW_SEQ;
  end

  always_comb begin
    if (reg_jump) begin
      assert_regjump_top_R8: assert (flow == FLOW_REG)
        else $error("register jump lost priority");
    end
  end

endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [JIDX_W-1:0] jfield,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_pc,
  output logic [XLEN-1:0]   jmp_pc
);

  localparam int unsigned HI_W  = XLEN - JIDX_W - 2;
  localparam int unsigned EXT_W = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] br_off;

  always_comb begin
    seq_pc = pc + STEP;
    br_off = {{EXT_W{jfield[IMM_W-1]}}, jfield[IMM_W-1:0], 2'b00};
    br_pc  = seq_pc + br_off;
    jmp_pc = {pc[XLEN-1 -: HI_W], jfield, 2'b00};
  end

endmodule

// File: rtl/npc_link.sv
module npc_link #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned RIDX_W   = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic              is_call,
  input  logic [XLEN-1:0]   ret_addr,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_data
);

  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  always_comb begin
    link_we   = is_call;
    link_idx  = is_call ? LINK_IDX : '0;
    link_data = is_call ? ret_addr : '0;
  end

endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned RIDX_W   = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic              alu_zero_i,
  input  logic              branch_i,
  input  logic              branch_ne_i,
  input  logic              jump_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_data_o
);

  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JIDX_W = 26;
  localparam int unsigned HI_W   = XLEN - JIDX_W - 2;

  flow_e           flow;
  logic            is_call;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;

  npc_decode u_decode (
    .opcode    (instr_i[31:26]),
    .funct     (instr_i[5:0]),
    .alu_zero  (alu_zero_i),
    .branch    (branch_i),
    .branch_ne (branch_ne_i),
    .jump      (jump_i),
    .flow      (flow),
    .is_call   (is_call)
  );

  npc_targets #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_targets (
    .pc     (pc_i),
    .jfield (instr_i[JIDX_W-1:0]),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  npc_link #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) u_link (
    .is_call   (is_call),
    .ret_addr  (seq_pc),
    .link_we   (link_we_o),
    .link_idx  (link_idx_o),
    .link_data (link_data_o)
  );

  always_comb begin
    unique case (flow)
      FLOW_REG: next_pc_o = rs_val_i;
      FLOW_JMP: next_pc_o = jmp_pc;
      FLOW_BR:  next_pc_o = br_pc;
      default:  next_pc_o = seq_pc;
    endcase
  end

  // Checks relating the decoded instruction, the strobes and the outputs.
  always_comb begin
    if (link_we_o) begin
      assert_link_fields_R6: assert (link_idx_o == RIDX_W'(LINK_REG)
                                     && link_data_o == pc_i + XLEN'(4))
        else $error("call link fields wrong");
    end else begin
      assert_link_quiet_R9: assert (link_idx_o == '0 && link_data_o == '0)
        else $error("link fields active without call");
    end
    if (instr_i[31:26] == OPC_RTYPE && instr_i[5:0] == FN_REGJMP) begin
      assert_regjump_R7: assert (next_pc_o == rs_val_i)
        else $error("register jump target wrong");
    end
    if ((jump_i || link_we_o) && flow != FLOW_REG) begin
      assert_jump_region_R5: assert (next_pc_o[XLEN-1 -: HI_W] == pc_i[XLEN-1 -: HI_W]
                                     && next_pc_o[1:0] == 2'b00)
        else $error("absolute target leaves region");
    end
    if (!branch_i && !jump_i && !link_we_o && flow != FLOW_REG) begin
      assert_seq_R1: assert (next_pc_o == pc_i + XLEN'(4))
        else $error("sequential step wrong");
    end
  end

endmodule

// File: tb/npc_link_unit_bench.sv
module npc_link_unit_bench;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] instr;
    logic [31:0] rs;
    logic        zero;
    logic        br;
    logic        ne;
    logic        jmp;
    logic [31:0] exp_pc;
    logic        exp_we;
  } vec_t;

  localparam int NVEC = 14;
  // Fields: pc, instr, rs, zero, br, ne, jmp, expected next pc, expected link enable
  localparam vec_t TAB [NVEC] = '{
    '{32'h0040_0000, 32'h0232_4020, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0040_0004, 1'b0}, // R1 add
    '{32'h0040_0000, 32'h2000_0008, 32'h5555_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0040_0004, 1'b0}, // R7 opcode 8 not regjump
    '{32'h0040_0000, 32'h1000_0004, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 32'h0040_0014, 1'b0}, // R2 taken
    '{32'h0040_0100, 32'h1000_FFFE, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 32'h0040_00FC, 1'b0}, // R4 backward
    '{32'h0040_0100, 32'h1000_FFFE, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 32'h0040_0104, 1'b0}, // R3 not taken
    '{32'h1000_0000, 32'h1400_0003, 32'h0,         1'b0, 1'b1, 1'b1, 1'b0, 32'h1000_0010, 1'b0}, // R3 ne taken
    '{32'h1000_0000, 32'h1400_0003, 32'h0,         1'b1, 1'b1, 1'b1, 1'b0, 32'h1000_0004, 1'b0}, // R3 ne not taken
    '{32'hA000_0010, 32'h0812_3456, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'hA048_D158, 1'b0}, // R5 jump
    '{32'h7000_0000, 32'h0FFF_FFFF, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFC, 1'b1}, // R6 call
    '{32'h0040_0000, 32'h03E0_0008, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 1'b0}, // R7 regjump
    '{32'h0040_0000, 32'h03E0_0008, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b1, 32'h1234_5678, 1'b0}, // R8 regjump wins
    '{32'h7000_0000, 32'h0FFF_FFFF, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFC, 1'b1}, // R8 call over branch
    '{32'hA000_0010, 32'h0812_3456, 32'h0,         1'b1, 1'b1, 1'b0, 1'b1, 32'hA048_D158, 1'b0}, // R8 jump over branch
    '{32'hFFFF_FFFC, 32'h0000_0020, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0}  // R10 wrap
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] pc, instr, rs_val;
  logic        alu_zero, branch, branch_ne, jump;
  logic [31:0] next_pc, link_data;
  logic        link_we;
  logic [4:0]  link_idx;

  int checks;
  int errors;
  bit done;

  npc_link_unit u_npc_link_unit (
    .pc_i        (pc),
    .instr_i     (instr),
    .rs_val_i    (rs_val),
    .alu_zero_i  (alu_zero),
    .branch_i    (branch),
    .branch_ne_i (branch_ne),
    .jump_i      (jump),
    .next_pc_o   (next_pc),
    .link_we_o   (link_we),
    .link_idx_o  (link_idx),
    .link_data_o (link_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    pc = v.pc; instr = v.instr; rs_val = v.rs;
    alu_zero = v.zero; branch = v.br; branch_ne = v.ne; jump = v.jmp;
    #1;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    pc = '0; instr = '0; rs_val = '0;
    alu_zero = 1'b0; branch = 1'b0; branch_ne = 1'b0; jump = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Quiet inputs: sequential step from 0, no link (R1, R9)
    check("R1 idle next pc", next_pc, 32'h4);
    check("R9 idle link enable", {31'b0, link_we}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      apply(TAB[i]);
      check("R1-R10 vector next pc", next_pc, TAB[i].exp_pc);
      check("R6 R9 vector link enable", {31'b0, link_we}, {31'b0, TAB[i].exp_we});
      if (TAB[i].exp_we) begin
        check("R6 link index", {27'b0, link_idx}, 32'd31);
        check("R6 link data", link_data, TAB[i].pc + 32'd4);
      end else begin
        check("R9 link index quiet", {27'b0, link_idx}, 32'd0);
        check("R9 link data quiet", link_data, 32'd0);
      end
    end

    // R6: call at the top of the address space; return address wraps
    apply('{32'hFFFF_FFFC, 32'h0C00_0001, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0});
    check("R6 call target high region", next_pc, 32'hF000_0004);
    check("R6 R10 call return wraps", link_data, 32'h0);
    // R5: jump strobe on a non-jump opcode uses the low 26 bits anyway
    apply('{32'h3000_0000, 32'h03FF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0});
    check("R5 full index", next_pc, 32'h3FFF_FFFC);
    // R2: largest positive offset
    apply('{32'h0000_0000, 32'h1000_7FFF, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0});
    check("R2 max positive offset", next_pc, 32'h0002_0000);
    // R4: most negative offset
    apply('{32'h0010_0000, 32'h1000_8000, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0});
    check("R4 min negative offset", next_pc, 32'h000E_0004);
    // R7: opcode 0 with another function code is not a register jump
    apply('{32'h0000_0100, 32'h03E0_0009, 32'hDEAD_BEE0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0});
    check("R7 other funct sequential", next_pc, 32'h0000_0104);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule